// File: doc/BRIEF.md
# Write-Drain Read/Write Turnaround Controller

This block is the front end of one memory channel. It accepts single-burst read and write requests, keeps reads in an arrival-ordered queue and writes in a small associative store, and decides each cycle whether the shared data bus carries reads or writes. Before a read is queued it is compared against every queued write. On a match the read is answered from the stored write data and never reaches the bus. A write to a burst that is already queued overwrites the stored data in place, so each burst has at most one pending write.

The direction policy uses hysteresis. Reads have the bus until the write store passes a high watermark. Writes then keep the bus until occupancy has fallen to a low watermark and a minimum batch of writes has gone out. If one direction has nothing pending and the other does, the bus also turns around. Every turnaround inserts a programmable dead time before the first command in the new direction. The back end takes one command per cycle when `cmdReady` is high. Bank timing and row policy are handled downstream.

Top module: `wdrain_ctrl`

## Requirements
- R1: Every request address is reduced to its burst address by clearing the low log2(BURST_BYTES) bits (BURST_BYTES=16 by default). Matching, merging and `cmdAddr` all use the burst address.
- R2: An accepted read whose burst address matches a queued write raises `fwdValid` in the next cycle, with `fwdData` equal to that entry's current data. No read command is ever issued for it.
- R3: An accepted write to a burst that is already queued replaces the stored data and uses no new entry. Exactly one write command is later issued for that burst, and it carries the newest data.
- R4: `reqReady` is low only when the target queue is full and the request does not match a queued write. A refused request (`reqValid` high, `reqReady` low) changes nothing and produces no command.
- R5: While write occupancy exceeds HI_MARK (default 5), no read command is issued and the bus turns to writes, even if reads are pending.
- R6: In write mode with reads pending, the bus returns to reads only when write occupancy is at most LO_MARK (default 2) and at least MIN_BATCH (default 5) writes have issued since the turnaround. The one exception is an empty write store.
- R7: With the read queue empty and writes pending, the bus turns to writes. With the write store empty and reads pending, it turns to reads.
- R8: A turnaround spends one decision cycle plus GAP_RW (default 2, toward writes) or GAP_WR (default 3, toward reads) further cycles without a command. Under continuous `cmdReady`, the first command in the new direction therefore comes GAP+2 cycles after the last command in the old one.
- R9: Reads are issued in arrival order. A new write takes the lowest-numbered free slot, and writes are issued lowest occupied slot first. `cmdWrite` is 1 for a write and 0 for a read, and `cmdData` holds the write data.
- R10: After reset both queues are empty, the bus is in read mode, `cmdValid` and `fwdValid` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqData | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted this cycle when high |
| fwdValid | output | 1 | Read answered from the write store |
| fwdData | output | DATA_W | Forwarded read data |
| cmdReady | input | 1 | Back end takes a command this cycle |
| cmdValid | output | 1 | Command offered |
| cmdWrite | output | 1 | Direction of the offered command |
| cmdAddr | output | ADDR_W | Burst address of the command |
| cmdData | output | DATA_W | Data of a write command |

## Verification
A corrupted occupancy count or batch counter shows up at the ports as a direction change in the wrong place within the command stream. The bench catches that the first time the back end takes commands, because it compares every issued command, in order, against a sequence built from the watermark rules. A stale valid bit in the write store surfaces within one cycle, either as a wrong `fwdValid` or as a duplicate or missing write command. The dead time is checked by measuring the cycle distance between the last command in one direction and the first in the other.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } busMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic popRd;
    logic popWr;
  } issueStrobe_t;

endpackage

// File: rtl/wdrain_queues.sv
module wdrain_queues
  import wdrain_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_BYTES = 16,
  parameter int RQ_DEPTH    = 4,
  parameter int WQ_DEPTH    = 8,
  localparam int RQ_CNT_W   = $clog2(RQ_DEPTH + 1),
  localparam int WQ_CNT_W   = $clog2(WQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  output logic                reqReady,
  input  issueStrobe_t        strobe,
  output logic [RQ_CNT_W-1:0] rdCount,
  output logic [WQ_CNT_W-1:0] wrCount,
  output logic [ADDR_W-1:0]   rdHeadAddr,
  output logic [ADDR_W-1:0]   wrSelAddr,
  output logic [DATA_W-1:0]   wrSelData,
  output logic                fwdValid,
  output logic [DATA_W-1:0]   fwdData
);

  localparam int RQ_PTR_W = $clog2(RQ_DEPTH);
  localparam int WQ_IDX_W = $clog2(WQ_DEPTH);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BURST_BYTES - 1);

  // read queue storage
  logic [ADDR_W-1:0]   rdMem [RQ_DEPTH];
  logic [RQ_PTR_W-1:0] rdWrPtr, rdRdPtr;

  // write store (associative)
  logic [WQ_DEPTH-1:0] wValid;
  logic [ADDR_W-1:0]   wAddr [WQ_DEPTH];
  logic [DATA_W-1:0]   wData [WQ_DEPTH];

  logic [ADDR_W-1:0]   reqBurst;
  logic [WQ_DEPTH-1:0] hitVec;
  logic                hit, freeFound, selFound;
  logic [WQ_IDX_W-1:0] hitIdx, freeIdx, selIdx;
  logic                acc, rdAcc, wrAcc, rdPush, wrAlloc, wrMerge, wrRel;

  assign reqBurst = reqAddr & ~OFS_MASK;

  // one comparator per slot
  for (genvar g = 0; g < WQ_DEPTH; g++) begin : g_cam
    assign hitVec[g] = wValid[g] && (wAddr[g] == reqBurst);
  end

  // priority encoders: match, lowest free slot, lowest occupied slot
  always_comb begin
    hit       = 1'b0;
    hitIdx    = '0;
    freeFound = 1'b0;
    freeIdx   = '0;
    selFound  = 1'b0;
    selIdx    = '0;
    for (int i = 0; i < WQ_DEPTH; i++) begin
      if (hitVec[i] && !hit) begin
        hit    = 1'b1;
        hitIdx = WQ_IDX_W'(i);
      end
      if (!wValid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = WQ_IDX_W'(i);
      end
      if (wValid[i] && !selFound) begin
        selFound = 1'b1;
        selIdx   = WQ_IDX_W'(i);
      end
    end
  end

  assign reqReady = hit || (reqWrite ? (wrCount < WQ_CNT_W'(WQ_DEPTH))
                                     : (rdCount < RQ_CNT_W'(RQ_DEPTH)));
  assign acc     = reqValid && reqReady;
  assign rdAcc   = acc && !reqWrite;
  assign wrAcc   = acc && reqWrite;
  assign rdPush  = rdAcc && !hit;
  assign wrAlloc = wrAcc && !hit;
  assign wrMerge = wrAcc && hit;
  // a merge into the slot being issued keeps that slot alive
  assign wrRel   = strobe.popWr && !(wrMerge && (hitIdx == selIdx));

  assign rdHeadAddr = rdMem[rdRdPtr];
  assign wrSelAddr  = wAddr[selIdx];
  assign wrSelData  = wData[selIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wValid   <= '0;
      wrCount  <= '0;
      rdCount  <= '0;
      rdWrPtr  <= '0;
      rdRdPtr  <= '0;
      fwdValid <= 1'b0;
    end else begin
      if (strobe.popWr) wValid[selIdx]  <= 1'b0;
      if (wrMerge)      wValid[hitIdx]  <= 1'b1;
      if (wrAlloc)      wValid[freeIdx] <= 1'b1;
      wrCount <= wrCount + WQ_CNT_W'(wrAlloc) - WQ_CNT_W'(wrRel);
      if (rdPush)       rdWrPtr <= rdWrPtr + 1'b1;
      if (strobe.popRd) rdRdPtr <= rdRdPtr + 1'b1;
      rdCount  <= rdCount + RQ_CNT_W'(rdPush) - RQ_CNT_W'(strobe.popRd);
      fwdValid <= rdAcc && hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rdPush)  rdMem[rdWrPtr] <= reqBurst;
    if (wrAlloc) begin
      wAddr[freeIdx] <= reqBurst;
      wData[freeIdx] <= reqData;
    end
    if (wrMerge) wData[hitIdx] <= reqData;
    if (rdAcc && hit) fwdData <= wData[hitIdx];
  end

  // R4: occupancy never passes the queue depths
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount <= RQ_CNT_W'(RQ_DEPTH)) && (wrCount <= WQ_CNT_W'(WQ_DEPTH)));

  // R3: a burst address lives in at most one slot
  a_r3_single_entry: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R3: the running count agrees with the slot valid bits
  a_r3_count_tracks: assert property (@(posedge clk) disable iff (!rstN)
    int'(wrCount) == $countones(wValid));

  // R2: a read that hits is answered in the next cycle
  a_r2_forward_next: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && hit) |=> fwdValid);

endmodule

// File: rtl/wdrain_sched.sv
module wdrain_sched
  import wdrain_pkg::*;
#(
  parameter int RQ_DEPTH  = 4,
  parameter int WQ_DEPTH  = 8,
  parameter int HI_MARK   = 5,
  parameter int LO_MARK   = 2,
  parameter int MIN_BATCH = 5,
  parameter int GAP_RW    = 2,
  parameter int GAP_WR    = 3,
  localparam int RQ_CNT_W = $clog2(RQ_DEPTH + 1),
  localparam int WQ_CNT_W = $clog2(WQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RQ_CNT_W-1:0] rdCount,
  input  logic [WQ_CNT_W-1:0] wrCount,
  input  logic                cmdReady,
  output logic                cmdValid,
  output logic                cmdWrite,
  output issueStrobe_t        strobe
);

  localparam int GAP_MAX = (GAP_RW > GAP_WR) ? GAP_RW : GAP_WR;
  localparam int GAP_W   = $clog2(GAP_MAX + 2);
  localparam int BATCH_W = $clog2(MIN_BATCH + 2);

  busMode_e            mode;
  logic [GAP_W-1:0]    gapCnt;
  logic [BATCH_W-1:0]  batchCnt;
  logic                idle, rdPend, wrPend, overHi, atLo, batchMet;
  logic                switchNow, fire;

  assign idle     = (gapCnt == '0);
  assign rdPend   = (rdCount != '0);
  assign wrPend   = (wrCount != '0);
  assign overHi   = (wrCount > WQ_CNT_W'(HI_MARK));
  assign atLo     = (wrCount <= WQ_CNT_W'(LO_MARK));
  assign batchMet = (batchCnt >= BATCH_W'(MIN_BATCH));

  always_comb begin
    if (mode == MODE_RD) switchNow = idle && (overHi || (!rdPend && wrPend));
    else                 switchNow = idle && rdPend && (!wrPend || (atLo && batchMet));
  end

  assign cmdValid     = idle && !switchNow && ((mode == MODE_RD) ? rdPend : wrPend);
  assign cmdWrite     = (mode == MODE_WR);
  assign fire         = cmdValid && cmdReady;
  assign strobe.popRd = fire && (mode == MODE_RD);
  assign strobe.popWr = fire && (mode == MODE_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_RD;
      gapCnt   <= '0;
      batchCnt <= '0;
    end else if (switchNow) begin
      mode     <= (mode == MODE_RD) ? MODE_WR : MODE_RD;
      gapCnt   <= (mode == MODE_RD) ? GAP_W'(GAP_RW) : GAP_W'(GAP_WR);
      batchCnt <= '0;
    end else if (!idle) begin
      gapCnt <= gapCnt - 1'b1;
    end else if (strobe.popWr && !batchMet) begin
      batchCnt <= batchCnt + 1'b1;
    end
  end

  // checker state: cycles since the last issued command and its direction
  logic [7:0] sinceFire;
  logic       lastDir, seenFire;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceFire <= '0;
      lastDir   <= 1'b0;
      seenFire  <= 1'b0;
    end else if (fire) begin
      sinceFire <= '0;
      lastDir   <= cmdWrite;
      seenFire  <= 1'b1;
    end else if (sinceFire != 8'hFF) begin
      sinceFire <= sinceFire + 1'b1;
    end
  end

  // R8: dead time before the first command after a turnaround
  a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rstN)
    (fire && seenFire && (cmdWrite != lastDir)) |->
      int'(sinceFire) >= (cmdWrite ? GAP_RW : GAP_WR) + 1);

  // R5: no read goes out while writes are above the high watermark
  a_r5_reads_stop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdWrite) |-> (wrCount <= WQ_CNT_W'(HI_MARK)));

  // R6: leaving write mode needs both watermark and batch, or an empty store
  a_r6_leave_write: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MODE_WR && mode == MODE_RD) |->
      ($past(wrCount) == '0) ||
      (($past(wrCount) <= WQ_CNT_W'(LO_MARK)) && ($past(batchCnt) >= BATCH_W'(MIN_BATCH))));

endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
  import wdrain_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_BYTES = 16,
  parameter int RQ_DEPTH    = 4,
  parameter int WQ_DEPTH    = 8,
  parameter int HI_MARK     = 5,
  parameter int LO_MARK     = 2,
  parameter int MIN_BATCH   = 5,
  parameter int GAP_RW      = 2,
  parameter int GAP_WR      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  input  logic              cmdReady,
  output logic              cmdValid,
  output logic              cmdWrite,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam int RQ_CNT_W = $clog2(RQ_DEPTH + 1);
  localparam int WQ_CNT_W = $clog2(WQ_DEPTH + 1);

  issueStrobe_t        strobe;
  logic [RQ_CNT_W-1:0] rdCount;
  logic [WQ_CNT_W-1:0] wrCount;
  logic [ADDR_W-1:0]   rdHeadAddr, wrSelAddr;
  logic [DATA_W-1:0]   wrSelData;

  wdrain_queues #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_BYTES(BURST_BYTES),
    .RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH)
  ) queues_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .reqReady(reqReady),
    .strobe(strobe), .rdCount(rdCount), .wrCount(wrCount),
    .rdHeadAddr(rdHeadAddr), .wrSelAddr(wrSelAddr), .wrSelData(wrSelData),
    .fwdValid(fwdValid), .fwdData(fwdData)
  );

  wdrain_sched #(
    .RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH), .HI_MARK(HI_MARK),
    .LO_MARK(LO_MARK), .MIN_BATCH(MIN_BATCH),
    .GAP_RW(GAP_RW), .GAP_WR(GAP_WR)
  ) sched_i (
    .clk(clk), .rstN(rstN),
    .rdCount(rdCount), .wrCount(wrCount), .cmdReady(cmdReady),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .strobe(strobe)
  );

  assign cmdAddr = cmdWrite ? wrSelAddr : rdHeadAddr;
  assign cmdData = cmdWrite ? wrSelData : '0;

endmodule

// File: tb/wdrain_ctrl_tb_top.sv
module wdrain_ctrl_tb_top;

  localparam int GAP_RW = 2;
  localparam int GAP_WR = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, cmdReady = 1'b0;
  logic [31:0] reqAddr = '0, reqData = '0;
  logic        reqReady, fwdValid, cmdValid, cmdWrite;
  logic [31:0] fwdData, cmdAddr, cmdData;

  always #5 clk = ~clk;

  wdrain_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .fwdValid(fwdValid), .fwdData(fwdData), .cmdReady(cmdReady),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastFireCyc = 0;
  bit finished = 1'b0;

  // scoreboard of expected commands
  bit          expW[$];
  logic [31:0] expA[$];
  logic [31:0] expD[$];
  int          expGap[$];
  string       expTag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input bit w, input logic [31:0] a, input logic [31:0] d,
                            input int gap, input string tag);
    expW.push_back(w); expA.push_back(a); expD.push_back(d);
    expGap.push_back(gap); expTag.push_back(tag);
  endtask

  // monitor: compares each command taken by the back end
  always @(negedge clk) begin
    if (rstN && cmdValid && cmdReady) begin
      if (expW.size() == 0) begin
        chk(1'b0, "R9 unexpected command", {cmdWrite, cmdAddr}, 0);
      end else begin
        bit w; logic [31:0] a, d; int g; string t;
        w = expW.pop_front(); a = expA.pop_front(); d = expD.pop_front();
        g = expGap.pop_front(); t = expTag.pop_front();
        chk(cmdWrite == w, {t, " direction"}, cmdWrite, w);
        chk(cmdAddr == a, {t, " address"}, cmdAddr, a);
        if (w) chk(cmdData == d, {t, " data"}, cmdData, d);
        if (g != 0) chk((cyc - lastFireCyc) == g, "R8 turnaround gap", cyc - lastFireCyc, g);
      end
      lastFireCyc = cyc;
    end
  end

  // driver: one request, checks reqReady; starts and ends just after a posedge
  task automatic send(input bit w, input logic [31:0] a, input logic [31:0] d,
                      input bit expReady, input string tag);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqData = d;
    @(negedge clk);
    chk(reqReady == expReady, {tag, " reqReady"}, reqReady, expReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic check_fwd(input bit expValid, input logic [31:0] expData, input string tag);
    @(negedge clk);
    chk(fwdValid == expValid, {tag, " fwdValid"}, fwdValid, expValid);
    if (expValid) chk(fwdData == expData, {tag, " fwdData"}, fwdData, expData);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10: reset state
    @(negedge clk);
    chk(cmdValid == 1'b0, "R10 cmdValid after reset", cmdValid, 0);
    chk(reqReady == 1'b1, "R10 reqReady after reset", reqReady, 1);
    chk(fwdValid == 1'b0, "R10 fwdValid after reset", fwdValid, 0);
    @(posedge clk); #1;

    // single read, then single write (R7 turn to writes), then read (R7 back)
    cmdReady = 1'b1;
    expect_cmd(1'b0, 32'h40, 0, 0, "R9 single read");
    send(1'b0, 32'h40, 0, 1'b1, "R9");
    idle(8);
    expect_cmd(1'b1, 32'h80, 32'hDEAD, 0, "R7 write with no reads");
    send(1'b1, 32'h80, 32'hDEAD, 1'b1, "R7");
    idle(10);
    expect_cmd(1'b0, 32'h90, 0, 0, "R7 read with no writes");
    send(1'b0, 32'h90, 0, 1'b1, "R7");
    idle(10);

    // merge and alignment with the back end stalled
    cmdReady = 1'b0;
    send(1'b1, 32'h104, 32'h11, 1'b1, "R1");
    send(1'b1, 32'h108, 32'h22, 1'b1, "R3 merge");
    send(1'b0, 32'h10C, 0, 1'b1, "R2");
    check_fwd(1'b1, 32'h22, "R2 forward merged data");
    check_fwd(1'b0, 0, "R2 forward pulse ends");
    expect_cmd(1'b1, 32'h100, 32'h22, 0, "R3 single merged write");
    cmdReady = 1'b1;
    idle(12);

    // high watermark with minimum batch deciding the exit
    cmdReady = 1'b0;
    send(1'b0, 32'h200, 0, 1'b1, "R9");
    send(1'b0, 32'h214, 0, 1'b1, "R1");
    for (int i = 0; i < 6; i++)
      send(1'b1, 32'h300 + 32'(i) * 32'h10, 32'h30 + 32'(i), 1'b1, "R5");
    for (int i = 0; i < 5; i++)
      expect_cmd(1'b1, 32'h300 + 32'(i) * 32'h10, 32'h30 + 32'(i), 0, "R5 writes before pending reads");
    expect_cmd(1'b0, 32'h200, 0, GAP_WR + 2, "R6 batch minimum then reads");
    expect_cmd(1'b0, 32'h210, 0, 0, "R1 aligned read");
    expect_cmd(1'b1, 32'h350, 32'h35, GAP_RW + 2, "R7 remaining write");
    idle(6);
    cmdReady = 1'b1;
    idle(30);

    // full queues, refusal, merge/forward at full, low watermark decides the exit
    cmdReady = 1'b0;
    for (int i = 0; i < 4; i++)
      send(1'b0, 32'h400 + 32'(i) * 32'h10, 0, 1'b1, "R9");
    send(1'b0, 32'h440, 0, 1'b0, "R4 read queue full");
    for (int i = 0; i < 8; i++)
      send(1'b1, 32'h500 + 32'(i) * 32'h10, 32'h50 + 32'(i), 1'b1, "R9");
    send(1'b1, 32'h580, 32'hEE, 1'b0, "R4 write store full");
    send(1'b1, 32'h528, 32'hAB, 1'b1, "R4 merge accepted when full");
    send(1'b0, 32'h51C, 0, 1'b1, "R4 hit read accepted when read queue full");
    check_fwd(1'b1, 32'h51, "R2 forward from slot");
    expect_cmd(1'b1, 32'h500, 32'h50, 0, "R9 slot order");
    expect_cmd(1'b1, 32'h510, 32'h51, 0, "R9 slot order");
    expect_cmd(1'b1, 32'h520, 32'hAB, 0, "R3 merged data at full");
    for (int i = 3; i < 6; i++)
      expect_cmd(1'b1, 32'h500 + 32'(i) * 32'h10, 32'h50 + 32'(i), 0, "R6 drain to low mark");
    expect_cmd(1'b0, 32'h400, 0, GAP_WR + 2, "R6 low mark then reads");
    for (int i = 1; i < 4; i++)
      expect_cmd(1'b0, 32'h400 + 32'(i) * 32'h10, 0, 0, "R9 read order");
    expect_cmd(1'b1, 32'h560, 32'h56, GAP_RW + 2, "R7 tail write");
    expect_cmd(1'b1, 32'h570, 32'h57, 0, "R7 tail write");
    cmdReady = 1'b1;
    idle(40);

    chk(expW.size() == 0, "R4 refused requests issued nothing, all expected seen", expW.size(), 0);
    @(negedge clk);
    chk(cmdValid == 1'b0, "R4 no command left over", cmdValid, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule